// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the clocking of a small 8-bit controller between three modes: normal running, idle and power-down. Software asks for a mode with a single-cycle request. The block then gates the CPU clock, the peripheral clock and the oscillator enable to suit that mode. Each low-power mode has its own way out. Idle ends when an enabled interrupt is pending or when the external reset pin is asserted. Power-down ignores everything except the external reset pin.

Two exits need care. When the external reset ends idle, the CPU keeps executing for a short run-off window before the register reset takes effect. During that window the block blocks internal RAM writes, while port writes stay allowed. When the external reset ends power-down, the oscillator is restarted first, and the register-reset strobe is then held for a settle period after the pin is released before the CPU clock comes back. Internal RAM contents are never touched by any of these resets. Only the special function registers see the reset strobe.

Top module: `lpm_ctrl`

## Requirements
- R1: After block reset `rst`, cpu_clk_en, per_clk_en and osc_en are 1 and sfr_rst, ram_wr_inhibit and irq_wake are 0.
- R2: An idle request while running clears cpu_clk_en on the next clock edge, and leaves per_clk_en and osc_en at 1. Idle requests and power-down requests made while idle have no effect.
- R3: A power-down request while running clears cpu_clk_en, per_clk_en and osc_en on the next edge. If idle and power-down are requested in the same cycle, power-down is taken.
- R4: In idle, a pending interrupt returns to running on the next edge and raises irq_wake for exactly one cycle, with sfr_rst kept at 0.
- R5: In power-down, pending interrupts and mode requests have no effect: all clock enables stay at 0.
- R6: In power-down, ext_reset sets osc_en to 1 and sfr_rst to 1 on the next edge, and cpu_clk_en and per_clk_en stay at 0 for as long as ext_reset is held.
- R7: After ext_reset is released following power-down, sfr_rst stays at 1 with cpu_clk_en at 0 for exactly SETTLE_CYC cycles, and then the block returns to running.
- R8: ext_reset in idle starts a run-off window of RUNOFF_MC*MC_CLKS cycles. During the window cpu_clk_en and ram_wr_inhibit are 1 and sfr_rst is 0. After the window, sfr_rst is 1 and ram_wr_inhibit is 0 until ext_reset is released.
- R9: ext_reset while running asserts sfr_rst on the next edge, with no RAM write inhibit. Releasing ext_reset returns to running on the next edge.
- R10: In idle, ext_reset takes priority over a pending interrupt in the same cycle, and no irq_wake is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high block reset |
| req_idle | input | 1 | Software request to enter idle |
| req_pdown | input | 1 | Software request to enter power-down |
| irq_pend | input | 1 | An enabled interrupt is pending |
| ext_reset | input | 1 | External hardware reset pin, active high |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable (timers, serial, interrupt logic) |
| osc_en | output | 1 | Oscillator enable |
| sfr_rst | output | 1 | Special function register reset strobe |
| ram_wr_inhibit | output | 1 | Blocks internal RAM writes |
| irq_wake | output | 1 | One-cycle wake pulse to the interrupt logic |

## Verification
Every output is a registered decode of the mode state, so a wrong state shows at the ports one edge after the input that caused it. A wrong run-off or settle count shows up as a window of ram_wr_inhibit or sfr_rst that is too short or too long. The bench measures these windows cycle by cycle, so an off-by-one error is seen on the cycle where the window should have ended. A power-down state that leaks an interrupt exit shows as clock enables turning back on without the reset pin.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_IDLE   = 3'd1,
    ST_PDOWN  = 3'd2,
    ST_PDRST  = 3'd3,
    ST_PDSET  = 3'd4,
    ST_RUNOFF = 3'd5,
    ST_RSTH   = 3'd6
  } lpm_state_e;

  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_IDLE  = 2'd1,
    REQ_PDOWN = 2'd2
  } lpm_req_e;

  typedef struct packed {
    logic cpu_clk_en;
    logic per_clk_en;
    logic osc_en;
    logic sfr_rst;
    logic ram_wr_inhibit;
  } lpm_ctl_t;

  function automatic lpm_ctl_t ctl_for(lpm_state_e s);
    lpm_ctl_t c;
    case (s)
      ST_RUN:    c = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
      ST_IDLE:   c = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
      ST_PDOWN:  c = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
      ST_PDRST:  c = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
      ST_PDSET:  c = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
      ST_RUNOFF: c = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
      ST_RSTH:   c = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
      default:   c = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/lpm_req_arb.sv
module lpm_req_arb
  import lpm_pkg::*;
(
  input  logic     req_idle,
  input  logic     req_pdown,
  output lpm_req_e req
);

  always_comb begin
    if (req_pdown)     req = REQ_PDOWN;
    else if (req_idle) req = REQ_IDLE;
    else               req = REQ_NONE;
  end

  always_comb begin
    if (req_pdown) AST_PDOWN_WINS: assert (req == REQ_PDOWN); // R3
  end

endmodule

// File: rtl/lpm_timer.sv
module lpm_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && cnt == '0) |=> 1'b0); // R7

endmodule

// File: rtl/lpm_out_reg.sv
module lpm_out_reg
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  lpm_state_e state_nxt,
  input  logic       wake_nxt,
  output lpm_ctl_t   ctl,
  output logic       irq_wake
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl      <= ctl_for(ST_RUN);
      irq_wake <= 1'b0;
    end else begin
      ctl      <= ctl_for(state_nxt);
      irq_wake <= wake_nxt;
    end
  end

  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq_wake |=> !irq_wake); // R4
  AST_WAKE_NO_SFR: assert property (@(posedge clk) disable iff (rst)
    irq_wake |-> (!ctl.sfr_rst && ctl.cpu_clk_en)); // R4
  AST_INHIBIT_EXCL: assert property (@(posedge clk) disable iff (rst)
    ctl.ram_wr_inhibit |-> (!ctl.sfr_rst && ctl.cpu_clk_en)); // R8
  AST_OSC_OFF_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    !ctl.osc_en |-> (!ctl.cpu_clk_en && !ctl.per_clk_en)); // R3

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int MC_CLKS    = 12,
  parameter int RUNOFF_MC  = 2,
  parameter int SETTLE_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic req_idle,
  input  logic req_pdown,
  input  logic irq_pend,
  input  logic ext_reset,
  output logic cpu_clk_en,
  output logic per_clk_en,
  output logic osc_en,
  output logic sfr_rst,
  output logic ram_wr_inhibit,
  output logic irq_wake
);

  localparam int RUNOFF_CYC = MC_CLKS * RUNOFF_MC;
  localparam int MAXV       = (RUNOFF_CYC > SETTLE_CYC) ? RUNOFF_CYC : SETTLE_CYC;
  localparam int CW         = $clog2(MAXV + 1);
  localparam logic [CW-1:0] RUNOFF_LD = CW'(RUNOFF_CYC - 1);
  localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE_CYC - 1);

  lpm_state_e    state, state_nxt;
  lpm_req_e      req;
  lpm_ctl_t      ctl;
  logic          wake_nxt;
  logic          t_load, t_dec, t_done;
  logic [CW-1:0] t_val;

  lpm_req_arb u_arb (
    .req_idle (req_idle),
    .req_pdown(req_pdown),
    .req      (req)
  );

  lpm_timer #(.CW(CW)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (t_load),
    .load_val(t_val),
    .dec     (t_dec),
    .done    (t_done)
  );

  always_comb begin
    state_nxt = state;
    wake_nxt  = 1'b0;
    t_load    = 1'b0;
    t_val     = '0;
    t_dec     = 1'b0;
    case (state)
      ST_RUN: begin
        if (ext_reset)              state_nxt = ST_RSTH;
        else if (req == REQ_PDOWN)  state_nxt = ST_PDOWN;
        else if (req == REQ_IDLE)   state_nxt = ST_IDLE;
      end
      ST_IDLE: begin
        if (ext_reset) begin
          state_nxt = ST_RUNOFF;
          t_load    = 1'b1;
          t_val     = RUNOFF_LD;
        end else if (irq_pend) begin
          state_nxt = ST_RUN;
          wake_nxt  = 1'b1;
        end
      end
      ST_PDOWN: begin
        if (ext_reset) state_nxt = ST_PDRST;
      end
      ST_PDRST: begin
        if (!ext_reset) begin
          state_nxt = ST_PDSET;
          t_load    = 1'b1;
          t_val     = SETTLE_LD;
        end
      end
      ST_PDSET: begin
        if (ext_reset)   state_nxt = ST_PDRST;
        else if (t_done) state_nxt = ST_RUN;
        else             t_dec     = 1'b1;
      end
      ST_RUNOFF: begin
        if (t_done) state_nxt = ST_RSTH;
        else        t_dec     = 1'b1;
      end
      ST_RSTH: begin
        if (!ext_reset) state_nxt = ST_RUN;
      end
      default: state_nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RUN;
    else     state <= state_nxt;
  end

  lpm_out_reg u_out (
    .clk      (clk),
    .rst      (rst),
    .state_nxt(state_nxt),
    .wake_nxt (wake_nxt),
    .ctl      (ctl),
    .irq_wake (irq_wake)
  );

  assign cpu_clk_en     = ctl.cpu_clk_en;
  assign per_clk_en     = ctl.per_clk_en;
  assign osc_en         = ctl.osc_en;
  assign sfr_rst        = ctl.sfr_rst;
  assign ram_wr_inhibit = ctl.ram_wr_inhibit;

  AST_PDOWN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PDOWN && !ext_reset) |=> (state == ST_PDOWN)); // R5
  AST_PDOWN_CLOCKS_OFF: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PDOWN) |-> (!osc_en && !cpu_clk_en)); // R3
  AST_IDLE_RESET_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && ext_reset) |=> !irq_wake); // R10
  AST_RSTH_SFR: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RSTH) |-> (sfr_rst && !ram_wr_inhibit)); // R9

endmodule

// File: tb/lpm_ctrl_tb_top.sv
module lpm_ctrl_tb_top;

  localparam int PERIOD  = 10;
  localparam int MC      = 12;
  localparam int RMC     = 2;
  localparam int SETTLE  = 16;
  localparam int RUNOFF  = MC * RMC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_idle = 1'b0, req_pdown = 1'b0, irq_pend = 1'b0, ext_reset = 1'b0;
  logic cpu_clk_en, per_clk_en, osc_en, sfr_rst, ram_wr_inhibit, irq_wake;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  lpm_ctrl #(.MC_CLKS(MC), .RUNOFF_MC(RMC), .SETTLE_CYC(SETTLE)) dut_i (
    .clk(clk), .rst(rst), .req_idle(req_idle), .req_pdown(req_pdown),
    .irq_pend(irq_pend), .ext_reset(ext_reset),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .sfr_rst(sfr_rst), .ram_wr_inhibit(ram_wr_inhibit), .irq_wake(irq_wake)
  );

  // outputs packed as {cpu, per, osc, sfr, inhibit, wake}
  localparam logic [5:0] O_RUN    = 6'b111000;
  localparam logic [5:0] O_IDLE   = 6'b011000;
  localparam logic [5:0] O_PDOWN  = 6'b000000;
  localparam logic [5:0] O_PDRST  = 6'b001100;
  localparam logic [5:0] O_WAKE   = 6'b111001;
  localparam logic [5:0] O_RUNOFF = 6'b111010;
  localparam logic [5:0] O_RSTH   = 6'b111100;

  // {idle, pdown, irq, ext_reset, expected[5:0]}
  localparam int NV = 11;
  localparam logic [9:0] VEC [0:NV-1] = '{
    {4'b0000, O_RUN},    // R1 stays running
    {4'b0010, O_RUN},    // interrupt while running: no wake
    {4'b1000, O_IDLE},   // R2 enter idle
    {4'b1100, O_IDLE},   // R2 requests ignored in idle
    {4'b0010, O_WAKE},   // R4 interrupt wakes
    {4'b0000, O_RUN},    // R4 pulse is one cycle
    {4'b1100, O_PDOWN},  // R3 both requests: power-down wins
    {4'b0010, O_PDOWN},  // R5 interrupt ignored
    {4'b1000, O_PDOWN},  // R5 idle request ignored
    {4'b0001, O_PDRST},  // R6 reset restarts oscillator
    {4'b0011, O_PDRST}   // R6 held reset
  };

  function automatic logic [5:0] outs();
    return {cpu_clk_en, per_clk_en, osc_en, sfr_rst, ram_wr_inhibit, irq_wake};
  endfunction

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: count actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(logic i, logic p, logic q, logic e);
    @(negedge clk);
    req_idle = i; req_pdown = p; irq_pend = q; ext_reset = e;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(posedge clk);
    #1;
    check("R1", outs(), O_RUN);
    @(negedge clk);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][9], VEC[k][8], VEC[k][7], VEC[k][6]);
      check($sformatf("vector %0d", k), outs(), VEC[k][5:0]);
    end

    // R7: settle window after reset release from power-down
    cnt = 0;
    step(0, 0, 1, 0);
    while (outs() == O_PDRST && cnt < 1000) begin
      cnt++;
      step(0, 0, 1, 0);
    end
    check_int("R7 settle length", cnt, SETTLE);
    check("R7 run after settle", outs(), O_RUN);

    // R7: reset reasserted during settle restarts the wait
    step(0, 1, 0, 0);
    check("R3 enter power-down", outs(), O_PDOWN);
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    repeat (3) step(0, 0, 0, 0);
    step(0, 0, 0, 1);
    check("R7 reassert reset", outs(), O_PDRST);
    cnt = 0;
    step(0, 0, 0, 0);
    while (outs() == O_PDRST && cnt < 1000) begin
      cnt++;
      step(0, 0, 0, 0);
    end
    check_int("R7 settle restarted", cnt, SETTLE);

    // R8 and R10: reset with interrupt during idle
    step(1, 0, 0, 0);
    check("R2 idle", outs(), O_IDLE);
    step(0, 0, 1, 1);
    check("R10 reset beats interrupt", outs(), O_RUNOFF);
    cnt = 1;
    step(0, 0, 1, 1);
    while (outs() == O_RUNOFF && cnt < 1000) begin
      cnt++;
      step(0, 0, 1, 1);
    end
    check_int("R8 run-off length", cnt, RUNOFF);
    check("R8 reset after run-off", outs(), O_RSTH);
    step(0, 0, 0, 1);
    check("R8 reset held", outs(), O_RSTH);
    step(0, 0, 0, 0);
    check("R8 back to run", outs(), O_RUN);

    // R8: short reset pulse in idle still runs the whole window
    step(1, 0, 0, 0);
    step(0, 0, 0, 1);
    cnt = 1;
    step(0, 0, 0, 0);
    while (outs() == O_RUNOFF && cnt < 1000) begin
      cnt++;
      step(0, 0, 0, 0);
    end
    check_int("R8 run-off after short pulse", cnt, RUNOFF);
    check("R8 one reset cycle", outs(), O_RSTH);
    step(0, 0, 0, 0);
    check("R8 run after pulse", outs(), O_RUN);

    // R9: reset while running
    step(0, 0, 0, 1);
    check("R9 reset in run", outs(), O_RSTH);
    step(1, 1, 0, 1);
    check("R9 requests ignored under reset", outs(), O_RSTH);
    step(0, 0, 0, 0);
    check("R9 release", outs(), O_RUN);

    // R1: block reset from a low-power state
    step(0, 1, 0, 0);
    check("R3 power-down again", outs(), O_PDOWN);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 block reset", outs(), O_RUN);
    @(negedge clk);
    rst = 1'b0;

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule